// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block keeps a byte-wide queue of upcoming opcode bytes between program memory and a CPU decoder. When the shared bus is free, it reads aligned 16-bit words from program memory. It appends the two bytes of each word to the tail of the queue, low-lane byte first. The decoder sees the two oldest bytes and the number of valid bytes. Each cycle it removes zero, one or two bytes through a consume count.

The same bus carries the core's operand reads and writes. An operand access always wins the bus over a prefetch. A prefetch that the bus has not yet acknowledged is dropped and issued again later. When the core takes a jump, the queue is emptied. In that same cycle the read of the word that holds the jump target goes out on the bus. If the target is odd, the low byte of that first word is thrown away. Wait states come from the memory side through a ready input. A cycle with ready low is stretched, and nothing new is started on the bus until it finishes.

Top module: `ifq_ctrl`

## Requirements
- R1: While reset is held, the valid count is 0. In the first cycle after reset, a prefetch read is issued at the reset address.
- R2: A flush sets the valid count to zero. In the next cycle the count equals only the bytes delivered by a target read that completed in the flush cycle.
- R3: In a flush cycle with no operand request, the bus carries a prefetch read at the target address with bit 0 cleared, in that same cycle.
- R4: A completed prefetch appends bus data bits [7:0] and then bits [15:8] to the queue. The decoder receives them in that order: the oldest byte on peek bits [7:0], the next on [15:8].
- R5: A prefetch is started only when at least 2 of the DEPTH byte slots are free. The valid count never exceeds DEPTH.
- R6: An operand request takes the bus in the cycle it is raised, in preference to a prefetch. Only one of read or write strobe is asserted at a time.
- R7: While the bus holds ready low, the current cycle keeps its address and delivers nothing. An operand read with one wait state completes in its second cycle, and no bytes enter the queue during it.
- R8: When the jump target is odd, the first word read for it adds only its high byte (bits [15:8]) to the queue.
- R9: After each completed prefetch, the prefetch address advances by 2. A flush restarts it at the aligned target. Across fetches and flushes, the bytes handed to the decoder are the program bytes at consecutive addresses from the target.
- R10: An operand write puts the 16-bit write data on the bus unchanged: low byte on bits [7:0], high byte on [15:8]. An operand read returns the bus data unchanged, and the done strobe rises in the cycle ready is seen.
- R11: Consuming N bytes (0, 1 or 2, never more than the valid count) removes the N oldest bytes. The rest keep their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Jump taken: empty queue, fetch from target |
| flush_addr_i | input | AW | Jump target byte address |
| consume_i | input | 2 | Bytes taken by the decoder this cycle |
| q_peek_o | output | 16 | Two oldest queue bytes, oldest in [7:0] |
| q_count_o | output | CW | Number of valid queue bytes |
| data_req_i | input | 1 | Operand access request, held until done |
| data_we_i | input | 1 | Operand access is a write |
| data_addr_i | input | AW | Operand word address (even) |
| data_wdata_i | input | 16 | Operand write data |
| data_rdata_o | output | 16 | Operand read data |
| data_done_o | output | 1 | Operand access completes this cycle |
| bus_addr_o | output | AW | Shared bus address |
| bus_rd_o | output | 1 | Bus read strobe |
| bus_wr_o | output | 1 | Bus write strobe |
| bus_fetch_o | output | 1 | Current bus cycle is a prefetch |
| bus_wdata_o | output | 16 | Bus write data |
| bus_rdata_i | input | 16 | Bus read data |
| bus_ready_i | input | 1 | Bus cycle completes this cycle |

## Verification
The memory model returns a byte computed from its address, so any byte the decoder takes can be checked against its address. This exposes lost, repeated or swapped bytes and wrong address steps. The consume count is swept over steady patterns of 0, 1 and 2 and over a rotating mix. The all-zero pattern fills the queue and shows the room limit, and the others show the shift order. Sixteen consecutive jump targets are tried, so both even and odd targets are covered and the single-byte first fill can be told apart from the two-byte fill. The same stream is then run with wait states on every bus cycle. Operand reads and writes are run with and without a wait state, which separates bus priority from wait stretching.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_FETCH = 2'd1,
        OWN_DATA  = 2'd2
    } bus_own_e;
endpackage

// File: rtl/ifq_arbiter.sv
module ifq_arbiter
    import ifq_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          data_req_i,
    input  logic          data_we_i,
    input  logic [AW-1:0] data_addr_i,
    input  logic          flush_i,
    input  logic [AW-1:0] flush_addr_i,
    input  logic [AW-1:0] fetch_addr_i,
    input  logic          room_i,
    output bus_own_e      own_o,
    output logic [AW-1:0] addr_o,
    output logic          rd_o,
    output logic          wr_o
);
    always_comb begin
        own_o  = OWN_NONE;
        addr_o = fetch_addr_i;
        rd_o   = 1'b0;
        wr_o   = 1'b0;
        if (data_req_i) begin
            own_o  = OWN_DATA;
            addr_o = data_addr_i;
            rd_o   = !data_we_i;
            wr_o   = data_we_i;
        end else if (flush_i) begin
            own_o  = OWN_FETCH;
            addr_o = {flush_addr_i[AW-1:1], 1'b0};
            rd_o   = 1'b1;
        end else if (room_i) begin
            own_o  = OWN_FETCH;
            rd_o   = 1'b1;
        end
    end
endmodule

// File: rtl/ifq_store.sv
module ifq_store #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic [1:0]    cons_i,
    input  logic [1:0]    push_n_i,
    input  logic [15:0]   push_bytes_i,
    output logic [CW-1:0] count_o,
    output logic [15:0]   peek_o,
    output logic          room_o
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] bytes;
        logic [CW-1:0]         cnt;
    } store_t;

    store_t st_d, st_q;
    logic [CW-1:0] base_cnt;

    always_comb begin
        st_d = st_q;
        // drop consumed bytes from the head
        for (int i = 0; i < DEPTH; i++) begin
            st_d.bytes[i] = '0;
            for (int k = 0; k < 3; k++) begin
                if (cons_i == k[1:0] && (i + k) < DEPTH)
                    st_d.bytes[i] = st_q.bytes[i + k];
            end
        end
        base_cnt = clear_i ? '0 : st_q.cnt - CW'(cons_i);
        // append delivered bytes at the tail
        for (int p = 0; p < DEPTH; p++) begin
            for (int j = 0; j < 2; j++) begin
                if (j < int'(push_n_i) && int'(base_cnt) + j == p)
                    st_d.bytes[p] = push_bytes_i[j*8 +: 8];
            end
        end
        st_d.cnt = base_cnt + CW'(push_n_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign peek_o  = {st_q.bytes[1], st_q.bytes[0]};
    assign room_o  = (DEPTH - int'(st_q.cnt)) >= 2;
endmodule

// File: rtl/ifq_ctrl.sv
module ifq_ctrl
    import ifq_pkg::*;
#(
    parameter int          AW       = 20,
    parameter int          DEPTH    = 8,
    parameter logic [AW-1:0] RESET_PC = '0,
    localparam int         CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic [AW-1:0] flush_addr_i,
    input  logic [1:0]    consume_i,
    output logic [15:0]   q_peek_o,
    output logic [CW-1:0] q_count_o,
    input  logic          data_req_i,
    input  logic          data_we_i,
    input  logic [AW-1:0] data_addr_i,
    input  logic [15:0]   data_wdata_i,
    output logic [15:0]   data_rdata_o,
    output logic          data_done_o,
    output logic [AW-1:0] bus_addr_o,
    output logic          bus_rd_o,
    output logic          bus_wr_o,
    output logic          bus_fetch_o,
    output logic [15:0]   bus_wdata_o,
    input  logic [15:0]   bus_rdata_i,
    input  logic          bus_ready_i
);
    typedef struct packed {
        logic [AW-1:0] fetch_addr;
        logic          skip_low;
    } pf_t;

    pf_t        pf_d, pf_q;
    bus_own_e   own;
    logic       room;
    logic       fetch_done;
    logic       skip_now;
    logic [1:0] push_n;
    logic [15:0] push_bytes;
    logic [1:0] cons_eff;

    ifq_arbiter #(.AW(AW)) u_arb (
        .data_req_i   (data_req_i),
        .data_we_i    (data_we_i),
        .data_addr_i  (data_addr_i),
        .flush_i      (flush_i),
        .flush_addr_i (flush_addr_i),
        .fetch_addr_i (pf_q.fetch_addr),
        .room_i       (room),
        .own_o        (own),
        .addr_o       (bus_addr_o),
        .rd_o         (bus_rd_o),
        .wr_o         (bus_wr_o)
    );

    ifq_store #(.DEPTH(DEPTH)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (flush_i),
        .cons_i       (cons_eff),
        .push_n_i     (push_n),
        .push_bytes_i (push_bytes),
        .count_o      (q_count_o),
        .peek_o       (q_peek_o),
        .room_o       (room)
    );

    always_comb begin
        pf_d       = pf_q;
        fetch_done = (own == OWN_FETCH) && bus_ready_i;
        skip_now   = flush_i ? flush_addr_i[0] : pf_q.skip_low;
        cons_eff   = flush_i ? 2'd0 : consume_i;
        push_n     = 2'd0;
        push_bytes = bus_rdata_i;
        if (fetch_done) begin
            if (skip_now) begin
                push_n     = 2'd1;
                push_bytes = {8'h00, bus_rdata_i[15:8]};
            end else begin
                push_n     = 2'd2;
            end
        end
        if (flush_i) begin
            pf_d.fetch_addr = {flush_addr_i[AW-1:1], 1'b0}
                              + (fetch_done ? AW'(2) : AW'(0));
            pf_d.skip_low   = flush_addr_i[0] && !fetch_done;
        end else if (fetch_done) begin
            pf_d.fetch_addr = pf_q.fetch_addr + AW'(2);
            pf_d.skip_low   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_q.fetch_addr <= {RESET_PC[AW-1:1], 1'b0};
            pf_q.skip_low   <= RESET_PC[0];
        end else begin
            pf_q <= pf_d;
        end
    end

    assign bus_fetch_o  = (own == OWN_FETCH);
    assign bus_wdata_o  = data_wdata_i;
    assign data_rdata_o = bus_rdata_i;
    assign data_done_o  = (own == OWN_DATA) && bus_ready_i;
endmodule

// File: rtl/ifq_chk.sv
module ifq_chk #(
    parameter int AW    = 20,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush_i,
    input logic [AW-1:0] flush_addr_i,
    input logic [1:0]    consume_i,
    input logic [CW-1:0] q_count_o,
    input logic          data_req_i,
    input logic [AW-1:0] data_addr_i,
    input logic [AW-1:0] bus_addr_o,
    input logic          bus_rd_o,
    input logic          bus_wr_o,
    input logic          bus_fetch_o,
    input logic          bus_ready_i
);
    // R2
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i && !(bus_fetch_o && bus_ready_i) |=> q_count_o == '0);

    // R3
    flush_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i && !data_req_i |->
            bus_rd_o && bus_fetch_o && bus_addr_o == {flush_addr_i[AW-1:1], 1'b0});

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_count_o) <= DEPTH);

    // R5
    room_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_count_o) > DEPTH - 2 && !flush_i && !data_req_i |-> !bus_rd_o);

    // R6
    data_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_req_i |-> !bus_fetch_o && bus_addr_o == data_addr_i);

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_o && bus_wr_o));

    // R7
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fetch_o && !bus_ready_i && consume_i == 2'd0 && !flush_i
            |=> q_count_o == $past(q_count_o));

    // R9
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fetch_o && bus_ready_i |=>
            (!bus_fetch_o || flush_i || bus_addr_o == $past(bus_addr_o) + AW'(2)));
endmodule

bind ifq_ctrl ifq_chk #(.AW(AW), .DEPTH(DEPTH)) u_ifq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .flush_addr_i (flush_addr_i),
    .consume_i    (consume_i),
    .q_count_o    (q_count_o),
    .data_req_i   (data_req_i),
    .data_addr_i  (data_addr_i),
    .bus_addr_o   (bus_addr_o),
    .bus_rd_o     (bus_rd_o),
    .bus_wr_o     (bus_wr_o),
    .bus_fetch_o  (bus_fetch_o),
    .bus_ready_i  (bus_ready_i)
);

// File: tb/tb_ifq_ctrl.sv
module tb_ifq_ctrl;
    localparam int PERIOD = 10;
    localparam int AW     = 20;
    localparam int DEPTH  = 8;
    localparam int CW     = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] RST_PC = 20'hFC010;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_i = 1'b0;
    logic [AW-1:0] flush_addr_i = '0;
    logic [1:0]    consume_i = '0;
    logic [15:0]   q_peek_o;
    logic [CW-1:0] q_count_o;
    logic          data_req_i = 1'b0;
    logic          data_we_i = 1'b0;
    logic [AW-1:0] data_addr_i = '0;
    logic [15:0]   data_wdata_i = '0;
    logic [15:0]   data_rdata_o;
    logic          data_done_o;
    logic [AW-1:0] bus_addr_o;
    logic          bus_rd_o, bus_wr_o, bus_fetch_o;
    logic [15:0]   bus_wdata_o;
    logic [15:0]   bus_rdata_i;
    logic          bus_ready_i;

    int vectors = 0;
    int miscompares = 0;
    logic [AW-1:0] exp_ptr;
    logic fwait = 1'b0, dwait = 1'b0;
    logic waited = 1'b0;
    logic [AW-1:0] last_addr = '0;

    always #(PERIOD/2) clk = ~clk;

    ifq_ctrl #(.AW(AW), .DEPTH(DEPTH), .RESET_PC(RST_PC)) dut (.*);

    function automatic logic [7:0] mb(input logic [AW-1:0] a);
        return a[7:0] ^ 8'hA5 ^ {a[11:8], 4'h0};
    endfunction

    // memory model: word from even address, optional one wait state
    always_comb begin
        bus_rdata_i = {mb({bus_addr_o[AW-1:1], 1'b1}), mb({bus_addr_o[AW-1:1], 1'b0})};
        bus_ready_i = !((bus_fetch_o ? fwait : dwait) && !(waited && last_addr == bus_addr_o));
    end
    always @(posedge clk) begin
        waited    <= (bus_rd_o || bus_wr_o) && !bus_ready_i;
        last_addr <= bus_addr_o;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one streaming cycle, entered and left at a falling edge
    task automatic step(input int want);
        int cnt = int'(q_count_o);
        int c = (want > cnt) ? cnt : want;
        chk(cnt <= DEPTH, "R5", cnt, DEPTH);
        if (cnt > DEPTH - 2) chk(!bus_rd_o, "R5", bus_rd_o, 0);
        if (c > 0) chk(q_peek_o[7:0] == mb(exp_ptr), "R4/R9/R11", q_peek_o[7:0], mb(exp_ptr));
        if (c > 1) chk(q_peek_o[15:8] == mb(exp_ptr + 1), "R4/R11", q_peek_o[15:8], mb(exp_ptr + 1));
        exp_ptr   = exp_ptr + AW'(c);
        consume_i = 2'(c);
        @(negedge clk);
        consume_i = 2'd0;
    endtask

    task automatic do_flush(input logic [AW-1:0] t);
        consume_i = 2'd0;
        flush_i = 1'b1;
        flush_addr_i = t;
        #1;
        chk(bus_rd_o && bus_fetch_o && bus_addr_o == {t[AW-1:1], 1'b0}, "R3", bus_addr_o, {t[AW-1:1], 1'b0});
        @(negedge clk);
        flush_i = 1'b0;
        if (!fwait) begin
            chk(int'(q_count_o) == (t[0] ? 1 : 2), "R2/R8", q_count_o, t[0] ? 1 : 2);
            chk(q_peek_o[7:0] == mb(t), "R8", q_peek_o[7:0], mb(t));
        end else begin
            chk(q_count_o == '0, "R2/R7", q_count_o, 0);
        end
        exp_ptr = t;
    endtask

    task automatic dacc(input bit we, input logic [AW-1:0] a, input logic [15:0] wd);
        int c0;
        data_req_i = 1'b1;
        data_we_i = we;
        data_addr_i = a;
        data_wdata_i = wd;
        #1;
        chk(!bus_fetch_o && bus_addr_o == a && bus_rd_o == !we && bus_wr_o == we, "R6", bus_addr_o, a);
        if (we) chk(bus_wdata_o == wd, "R10", bus_wdata_o, wd);
        if (dwait) begin
            chk(!data_done_o, "R7", data_done_o, 0);
            c0 = int'(q_count_o);
            @(negedge clk);
            chk(int'(q_count_o) == c0, "R7", q_count_o, c0);
            chk(!bus_fetch_o && bus_addr_o == a, "R7", bus_addr_o, a);
        end
        chk(data_done_o, "R10", data_done_o, 1);
        if (!we) chk(data_rdata_o == {mb(a + 1), mb(a)}, "R10", data_rdata_o, {mb(a + 1), mb(a)});
        @(negedge clk);
        data_req_i = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        miscompares++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(q_count_o == '0, "R1", q_count_o, 0);
        rst_n = 1'b1;
        #1;
        chk(bus_rd_o && bus_fetch_o && bus_addr_o == RST_PC, "R1", bus_addr_o, RST_PC);
        @(negedge clk);
        exp_ptr = RST_PC;

        // fill without consuming: queue stops at DEPTH
        for (int i = 0; i < 8; i++) step(0);
        chk(int'(q_count_o) == DEPTH, "R5", q_count_o, DEPTH);
        chk(!bus_rd_o, "R5", bus_rd_o, 0);
        for (int pat = 1; pat < 4; pat++)
            for (int i = 0; i < 40; i++) step(pat == 3 ? (i % 3) : pat);

        // every target parity and alignment over a small window
        for (int t = 0; t < 16; t++) begin
            do_flush(20'h00340 + AW'(t));
            for (int i = 0; i < 12; i++) step((i + t) % 3);
        end

        // wait states on prefetch
        fwait = 1'b1;
        do_flush(20'h00571);
        for (int i = 0; i < 40; i++) step(i % 3);
        do_flush(20'h00600);
        for (int i = 0; i < 30; i++) step(2);
        fwait = 1'b0;

        // operand accesses interleaved with the stream
        dacc(1'b0, 20'h04000, 16'h0);
        for (int i = 0; i < 5; i++) step(1);
        dwait = 1'b1;
        dacc(1'b0, 20'h04002, 16'h0);
        for (int i = 0; i < 5; i++) step(2);
        dacc(1'b1, 20'h04004, 16'hBEEF);
        dwait = 1'b0;
        dacc(1'b1, 20'h04006, 16'h1234);
        for (int i = 0; i < 20; i++) step(i % 3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule